// File: doc/BRIEF.md
# Tape Controller Register Interface

This block is the register file of a tape controller that serves up to eight unit numbers, of which the first four can carry status. It answers on two word-addressed ports. The local port is the one that processor software uses. The remote port is the one that an emulating host uses to feed tape status in and to complete commands. Six registers are decoded: status, command, byte count, bus address, data buffer and a remote-load register. The last one carries one unit's status flags.

The unit field of the command register selects which unit's flags appear in the status register. A local command write with the go bit set hands the command to the remote side through a one-cycle attention pulse, and the controller stays busy until the remote side writes a done command. The block also raises an interrupt request with a fixed vector. It does so when interrupt-enable and controller-ready are both true as a result of a command write or of a done command.

Reads on both ports are combinational in the request cycle. Writes take effect at the next rising clock edge.

Top module: `tape_ctl_regs`

## Requirements
- R1: After reset the command register reads 0x0080 (ready set, all else zero). Byte count, bus address and data buffer read 0. Status reads 0x0001. `irq_req` and `rem_attn` are low.
- R2: Word offsets 0 to 5 (status, command, byte count, bus address, data buffer, remote-load) acknowledge on both ports. Offsets 6 and 7 do not acknowledge.
- R3: On the remote port, a remote-load write (offset 5) stores bits 4:0 as the selected unit's flags. The bit order is end-of-file(4), end-of-tape(3), online(2), beginning-of-tape(1), write-locked(0). A remote-load read returns those flags in bits 4:0 and the selected unit number in bits 10:8.
- R4: A status read returns bit 0 (unit ready) always 1, together with the selected unit's flags: end-of-file in bit 14, end-of-tape in bit 10, online in bit 6, beginning-of-tape in bit 5 and write-locked in bit 2. Writes to status change nothing.
- R5: When the selected unit is 4 to 7, status reads 0x0001 and the remote-load flags read 0.
- R6: The command register layout is go(0), function(3:1), extended address(5:4), interrupt-enable(6), ready(7), unit(10:8), even parity(11), density(14:13). Bits 15, 12 and 0 read 0, and bit 7 reads the ready state rather than the written value.
- R7: Byte count and data buffer keep all 16 written bits. Bus address forces bit 0 to 0 (0x7777 reads 0x7776).
- R8: A write to byte count, bus address or data buffer from either port is visible on both ports. When both ports write the same register in the same cycle, the local value is kept.
- R9: A local command write with go=1 while ready clears ready and makes `rem_attn` high for exactly one cycle. A go write while busy produces no pulse.
- R10: A remote command write copies bits 10:8 into the unit field and leaves the other command fields as they were. If bit 15 is set, the write also sets ready (done).
- R11: A local command write with interrupt-enable=1 and go=0 while ready raises `irq_req` in the next cycle, with `irq_vector` = 0224 octal. The other registers keep their values.
- R12: A done command that raises ready while interrupt-enable is 1 raises `irq_req`.
- R13: `irq_req` is cleared by `irq_ack` or by a local command write with interrupt-enable=0. When a new request and `irq_ack` fall in the same cycle, the request stays asserted.
- R14: A local access to remote-load is acknowledged, reads as 0, and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local port access request |
| loc_we | input | 1 | Local port write enable |
| loc_addr | input | 3 | Local word offset |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data |
| loc_ack | output | 1 | Local access acknowledged |
| rem_req | input | 1 | Remote port access request |
| rem_we | input | 1 | Remote port write enable |
| rem_addr | input | 3 | Remote word offset |
| rem_wdata | input | 16 | Remote write data |
| rem_rdata | output | 16 | Remote read data |
| rem_ack | output | 1 | Remote access acknowledged |
| rem_attn | output | 1 | One-cycle pulse when a go command is accepted |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 9 | Interrupt vector (0224 octal) |
| irq_ack | input | 1 | Interrupt acknowledge from the bus |

## Verification
Two collisions can occur in a single cycle, and the bench provokes each one by driving both events on the same clock edge.

In the first, the local and remote ports write the byte count register together. The bench then reads the register back from both ports and expects the local value.

In the second, the bus acknowledges a pending interrupt in the same cycle that a local command write with interrupt-enable set creates a new one. The bench expects `irq_req` to stay high, and then to fall after a lone acknowledge.

// File: rtl/tape_regs_pkg.sv
package tape_regs_pkg;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int UW = 3;

    // word offsets; the order is fixed by the bus decode
    localparam logic [AW-1:0] RG_STAT  = 3'd0;
    localparam logic [AW-1:0] RG_CMD   = 3'd1;
    localparam logic [AW-1:0] RG_BCNT  = 3'd2;
    localparam logic [AW-1:0] RG_BADR  = 3'd3;
    localparam logic [AW-1:0] RG_DBUF  = 3'd4;
    localparam logic [AW-1:0] RG_RLOAD = 3'd5;

    // command word bit positions
    localparam int CB_GO   = 0;
    localparam int CB_IE   = 6;
    localparam int CB_RDY  = 7;
    localparam int CB_DONE = 15;

    typedef struct packed {
        logic eof;
        logic eot;
        logic onl;
        logic bot;
        logic wrl;
    } unit_flags_t;

    typedef struct packed {
        logic [1:0]    dens;
        logic          evpar;
        logic [UW-1:0] unit;
        logic          rdy;
        logic          ie;
        logic [1:0]    xadr;
        logic [2:0]    func;
    } cmd_t;

    typedef struct packed {
        cmd_t          cmd;
        logic [DW-1:0] bcnt;
        logic [DW-1:0] badr;
        logic [DW-1:0] dbuf;
        logic          attn;
    } ctl_t;

endpackage

// File: rtl/tape_unit_bank.sv
module tape_unit_bank
    import tape_regs_pkg::*;
#(
    parameter int NUNITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [UW-1:0] ld_unit,
    input  unit_flags_t   ld_flags,
    input  logic [UW-1:0] sel_unit,
    output unit_flags_t   sel_flags
);

    unit_flags_t flags_all [NUNITS];

    for (genvar g = 0; g < NUNITS; g++) begin : g_unit
        unit_flags_t fl_d, fl_q;

        always_comb begin
            fl_d = fl_q;
            if (ld_en && ld_unit == UW'(g))
                fl_d = ld_flags;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) fl_q <= '0;
            else        fl_q <= fl_d;
        end

        assign flags_all[g] = fl_q;

        // R3
        unit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_en && ld_unit == UW'(g)) |=> (fl_q == $past(ld_flags)));
    end

    // unit numbers without storage read as all-clear (offline)
    always_comb begin
        sel_flags = '0;
        for (int i = 0; i < NUNITS; i++)
            if (sel_unit == UW'(i))
                sel_flags = flags_all[i];
    end

endmodule

// File: rtl/tape_irq_gen.sv
module tape_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic ack,
    output logic irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set_evt)              irq_d = 1'b1;
        else if (clr_evt || ack)  irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    // R13
    irq_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_evt) |=> !irq);

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq);

endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
    import tape_regs_pkg::*;
#(
    parameter int          NUNITS  = 4,
    parameter int          VEC_W   = 9,
    parameter logic [8:0]  IRQ_VEC = 9'o224
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  logic             loc_we,
    input  logic [AW-1:0]    loc_addr,
    input  logic [DW-1:0]    loc_wdata,
    output logic [DW-1:0]    loc_rdata,
    output logic             loc_ack,
    input  logic             rem_req,
    input  logic             rem_we,
    input  logic [AW-1:0]    rem_addr,
    input  logic [DW-1:0]    rem_wdata,
    output logic [DW-1:0]    rem_rdata,
    output logic             rem_ack,
    output logic             rem_attn,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    input  logic             irq_ack
);

    ctl_t        q, d;
    unit_flags_t sel_flags;
    logic        loc_wr, rem_wr, go_acc, done_cmd, rl_load;
    logic        irq_set, irq_clr;
    logic [DW-1:0] stat_word, cmd_word, rload_word;

    assign loc_wr   = loc_req && loc_we;
    assign rem_wr   = rem_req && rem_we;
    assign go_acc   = loc_wr && loc_addr == RG_CMD && loc_wdata[CB_GO] && q.cmd.rdy;
    assign done_cmd = rem_wr && rem_addr == RG_CMD && rem_wdata[CB_DONE];
    assign rl_load  = rem_wr && rem_addr == RG_RLOAD;

    tape_unit_bank #(.NUNITS(NUNITS)) u_units (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (rl_load),
        .ld_unit  (q.cmd.unit),
        .ld_flags (unit_flags_t'(rem_wdata[4:0])),
        .sel_unit (q.cmd.unit),
        .sel_flags(sel_flags)
    );

    // next-state computation; remote writes first, local last so local wins
    always_comb begin
        d      = q;
        d.attn = go_acc;

        if (rem_wr) begin
            unique case (rem_addr)
                RG_CMD: begin
                    d.cmd.unit = rem_wdata[10:8];
                    if (rem_wdata[CB_DONE]) d.cmd.rdy = 1'b1;
                end
                RG_BCNT: d.bcnt = rem_wdata;
                RG_BADR: d.badr = {rem_wdata[DW-1:1], 1'b0};
                RG_DBUF: d.dbuf = rem_wdata;
                default: ;
            endcase
        end

        if (loc_wr) begin
            unique case (loc_addr)
                RG_CMD: begin
                    d.cmd.dens  = loc_wdata[14:13];
                    d.cmd.evpar = loc_wdata[11];
                    d.cmd.unit  = loc_wdata[10:8];
                    d.cmd.ie    = loc_wdata[CB_IE];
                    d.cmd.xadr  = loc_wdata[5:4];
                    d.cmd.func  = loc_wdata[3:1];
                    if (go_acc) d.cmd.rdy = 1'b0;
                end
                RG_BCNT: d.bcnt = loc_wdata;
                RG_BADR: d.badr = {loc_wdata[DW-1:1], 1'b0};
                RG_DBUF: d.dbuf = loc_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.cmd.rdy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // interrupt events
    assign irq_set = (loc_wr && loc_addr == RG_CMD && loc_wdata[CB_IE]
                      && !loc_wdata[CB_GO] && q.cmd.rdy)
                   || (done_cmd && !q.cmd.rdy && d.cmd.rdy && d.cmd.ie);
    assign irq_clr = loc_wr && loc_addr == RG_CMD && !loc_wdata[CB_IE];

    tape_irq_gen u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(irq_set),
        .clr_evt(irq_clr),
        .ack    (irq_ack),
        .irq    (irq_req)
    );

    assign irq_vector = VEC_W'(IRQ_VEC);
    assign rem_attn   = q.attn;

    // read words
    always_comb begin
        stat_word     = '0;
        stat_word[0]  = 1'b1;
        stat_word[14] = sel_flags.eof;
        stat_word[10] = sel_flags.eot;
        stat_word[6]  = sel_flags.onl;
        stat_word[5]  = sel_flags.bot;
        stat_word[2]  = sel_flags.wrl;

        cmd_word = {1'b0, q.cmd.dens, 1'b0, q.cmd.evpar, q.cmd.unit,
                    q.cmd.rdy, q.cmd.ie, q.cmd.xadr, q.cmd.func, 1'b0};

        rload_word       = '0;
        rload_word[10:8] = q.cmd.unit;
        rload_word[4:0]  = sel_flags;
    end

    function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] a, input logic remote);
        unique case (a)
            RG_STAT:  return stat_word;
            RG_CMD:   return cmd_word;
            RG_BCNT:  return q.bcnt;
            RG_BADR:  return q.badr;
            RG_DBUF:  return q.dbuf;
            RG_RLOAD: return remote ? rload_word : '0;
            default:  return '0;
        endcase
    endfunction

    assign loc_ack   = loc_req && loc_addr <= RG_RLOAD;
    assign rem_ack   = rem_req && rem_addr <= RG_RLOAD;
    assign loc_rdata = loc_ack ? rd_mux(loc_addr, 1'b0) : '0;
    assign rem_rdata = rem_ack ? rd_mux(rem_addr, 1'b1) : '0;

    // R7
    badr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && loc_addr == RG_BADR) |=> (q.badr == ($past(loc_wdata) & 16'hFFFE)));

    // R9
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && loc_addr == RG_CMD && loc_wdata[CB_GO] && q.cmd.rdy)
        |=> (rem_attn && !q.cmd.rdy));

    // R9
    attn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rem_attn |=> !rem_attn);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cmd && !(loc_wr && loc_addr == RG_CMD && loc_wdata[CB_GO])) |=> q.cmd.rdy);

endmodule

// File: tb/tape_ctl_regs_bench.sv
module tape_ctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req = 0, loc_we = 0, rem_req = 0, rem_we = 0, irq_ack = 0;
    logic [2:0]  loc_addr = '0, rem_addr = '0;
    logic [15:0] loc_wdata = '0, rem_wdata = '0;
    logic [15:0] loc_rdata, rem_rdata;
    logic        loc_ack, rem_ack, rem_attn, irq_req;
    logic [8:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tape_ctl_regs u_tape_ctl_regs (
        .clk(clk), .rst_n(rst_n),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_ack(loc_ack),
        .rem_req(rem_req), .rem_we(rem_we), .rem_addr(rem_addr),
        .rem_wdata(rem_wdata), .rem_rdata(rem_rdata), .rem_ack(rem_ack),
        .rem_attn(rem_attn), .irq_req(irq_req), .irq_vector(irq_vector),
        .irq_ack(irq_ack)
    );

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic lwr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = a; loc_wdata = v;
        @(negedge clk);
        loc_req = 0; loc_we = 0;
    endtask

    task automatic rwr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        rem_req = 1; rem_we = 1; rem_addr = a; rem_wdata = v;
        @(negedge clk);
        rem_req = 0; rem_we = 0;
    endtask

    task automatic lrd(input logic [2:0] a, output logic [15:0] v, output logic k);
        @(negedge clk);
        loc_req = 1; loc_we = 0; loc_addr = a;
        #2;
        v = loc_rdata; k = loc_ack;
        loc_req = 0;
    endtask

    task automatic rrd(input logic [2:0] a, output logic [15:0] v, output logic k);
        @(negedge clk);
        rem_req = 1; rem_we = 0; rem_addr = a;
        #2;
        v = rem_rdata; k = rem_ack;
        rem_req = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v; logic k;
        lrd(3'd1, v, k); chk("R1 cmd", v, 16'h0080);
        lrd(3'd2, v, k); chk("R1 bcnt", v, 16'h0000);
        lrd(3'd3, v, k); chk("R1 badr", v, 16'h0000);
        lrd(3'd4, v, k); chk("R1 dbuf", v, 16'h0000);
        lrd(3'd0, v, k); chk("R1 stat", v, 16'h0001);
        chk("R1 irq", {15'd0, irq_req}, 16'd0);
        chk("R1 attn", {15'd0, rem_attn}, 16'd0);
    endtask

    task automatic t_decode();
        logic [15:0] v; logic k;
        lrd(3'd6, v, k); chk("R2 loc off6 ack", {15'd0, k}, 16'd0);
        lrd(3'd7, v, k); chk("R2 loc off7 ack", {15'd0, k}, 16'd0);
        rrd(3'd6, v, k); chk("R2 rem off6 ack", {15'd0, k}, 16'd0);
        rrd(3'd7, v, k); chk("R2 rem off7 ack", {15'd0, k}, 16'd0);
        lrd(3'd4, v, k); chk("R2 loc off4 ack", {15'd0, k}, 16'd1);
        rrd(3'd5, v, k); chk("R2 rem off5 ack", {15'd0, k}, 16'd1);
    endtask

    task automatic t_units();
        logic [15:0] v; logic k;
        rwr(3'd1, 16'h0000); rwr(3'd5, 16'h001C);
        rwr(3'd1, 16'h0100); rwr(3'd5, 16'h0016);
        rwr(3'd1, 16'h0200); rwr(3'd5, 16'h000D);
        rwr(3'd1, 16'h0300); rwr(3'd5, 16'h0007);
        rwr(3'd1, 16'h0200);
        rrd(3'd5, v, k); chk("R3 rload read unit2", v, 16'h020D);
        lwr(3'd1, 16'h0000); lrd(3'd0, v, k); chk("R4 stat unit0", v, 16'h4441);
        lwr(3'd1, 16'h0100); lrd(3'd0, v, k); chk("R4 stat unit1", v, 16'h4061);
        lwr(3'd1, 16'h0200); lrd(3'd0, v, k); chk("R4 stat unit2", v, 16'h0445);
        lwr(3'd1, 16'h0300); lrd(3'd0, v, k); chk("R4 stat unit3", v, 16'h0065);
        lwr(3'd0, 16'hFFFF); lrd(3'd0, v, k); chk("R4 stat write ignored", v, 16'h0065);
        lwr(3'd1, 16'h0500); lrd(3'd0, v, k); chk("R5 stat unit5", v, 16'h0001);
        rrd(3'd5, v, k); chk("R5 rload unit5", v, 16'h0500);
        lwr(3'd1, 16'h0700); lrd(3'd0, v, k); chk("R5 stat unit7", v, 16'h0001);
    endtask

    task automatic t_cmd();
        logic [15:0] v; logic k;
        lwr(3'd1, 16'hFFBE);
        lrd(3'd1, v, k); chk("R6 cmd fields", v, 16'h6FBE);
        rrd(3'd1, v, k); chk("R6 cmd remote view", v, 16'h6FBE);
        lwr(3'd1, 16'h0000);
        lrd(3'd1, v, k); chk("R6 cmd cleared", v, 16'h0080);
    endtask

    task automatic t_data();
        logic [15:0] v; logic k;
        lwr(3'd2, 16'h8888); lrd(3'd2, v, k); chk("R7 bcnt", v, 16'h8888);
        lwr(3'd3, 16'h7777); lrd(3'd3, v, k); chk("R7 badr bit0", v, 16'h7776);
        lwr(3'd4, 16'h5A5B); lrd(3'd4, v, k); chk("R7 dbuf", v, 16'h5A5B);
        rwr(3'd3, 16'h4321);
        lrd(3'd3, v, k); chk("R8 badr rem->loc", v, 16'h4320);
        rrd(3'd3, v, k); chk("R8 badr rem->rem", v, 16'h4320);
        lwr(3'd2, 16'h1234); rrd(3'd2, v, k); chk("R8 bcnt loc->rem", v, 16'h1234);
        rwr(3'd4, 16'hC3C3); lrd(3'd4, v, k); chk("R8 dbuf rem->loc", v, 16'hC3C3);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = 3'd2; loc_wdata = 16'hAAAA;
        rem_req = 1; rem_we = 1; rem_addr = 3'd2; rem_wdata = 16'h5555;
        @(negedge clk);
        loc_req = 0; loc_we = 0; rem_req = 0; rem_we = 0;
        lrd(3'd2, v, k); chk("R8 collision local view", v, 16'hAAAA);
        rrd(3'd2, v, k); chk("R8 collision remote view", v, 16'hAAAA);
    endtask

    task automatic t_go();
        logic [15:0] v; logic k;
        lwr(3'd1, 16'h0000);
        lwr(3'd1, 16'h0001);
        chk("R9 attn high", {15'd0, rem_attn}, 16'd1);
        @(negedge clk);
        chk("R9 attn one cycle", {15'd0, rem_attn}, 16'd0);
        lrd(3'd1, v, k); chk("R9 ready cleared", v, 16'h0000);
        lwr(3'd1, 16'h0001);
        chk("R9 go while busy no attn", {15'd0, rem_attn}, 16'd0);
        rwr(3'd1, 16'h8000);
        lrd(3'd1, v, k); chk("R10 done sets ready", v, 16'h0080);
        lwr(3'd1, 16'h2010);
        rwr(3'd1, 16'h0300);
        lrd(3'd1, v, k); chk("R10 remote unit only", v, 16'h2390);
        lwr(3'd1, 16'h0300);
        lwr(3'd5, 16'h0000);
        rrd(3'd5, v, k); chk("R14 local rload write ignored", v, 16'h0307);
        lrd(3'd5, v, k); chk("R14 local rload reads 0", v, 16'h0000);
        chk("R14 local rload ack", {15'd0, k}, 16'd1);
    endtask

    task automatic t_irq();
        logic [15:0] v; logic k;
        lwr(3'd1, 16'h0000);
        lwr(3'd2, 16'hFF00);
        lwr(3'd3, 16'h8800);
        lwr(3'd1, 16'h0040);
        chk("R11 irq raised", {15'd0, irq_req}, 16'd1);
        chk("R11 vector", {7'd0, irq_vector}, 16'd148);
        lrd(3'd1, v, k); chk("R11 cmd", v, 16'h00C0);
        lrd(3'd2, v, k); chk("R11 bcnt unchanged", v, 16'hFF00);
        lrd(3'd3, v, k); chk("R11 badr unchanged", v, 16'h8800);
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk("R13 ack clears", {15'd0, irq_req}, 16'd0);
        lwr(3'd1, 16'h0040);
        lwr(3'd1, 16'h0000);
        chk("R13 ie=0 clears", {15'd0, irq_req}, 16'd0);
        lwr(3'd1, 16'h0041);
        chk("R12 go with ie no irq", {15'd0, irq_req}, 16'd0);
        rwr(3'd1, 16'h8000);
        chk("R12 done raises irq", {15'd0, irq_req}, 16'd1);
        @(negedge clk);
        loc_req = 1; loc_we = 1; loc_addr = 3'd1; loc_wdata = 16'h0040; irq_ack = 1;
        @(negedge clk);
        loc_req = 0; loc_we = 0; irq_ack = 0;
        chk("R13 set beats ack", {15'd0, irq_req}, 16'd1);
        @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
        chk("R13 lone ack clears", {15'd0, irq_req}, 16'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_decode();
        t_units();
        t_cmd();
        t_data();
        t_go();
        t_irq();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule